// File: doc/BRIEF.md
# Programmable Reload Interval Timer

This block is a free-running interval timer for a processor subsystem. Software loads a reload value, which is normally the negative of the wanted period, into the next-interval register. It copies that value into the count register and sets the run bit. From then on the count advances by one on every cycle in which the microsecond tick enable is high. When the count rolls over past its all-ones value, the timer raises its done flag and reloads the count from the next-interval register. If the interrupt enable is set, it also raises a level interrupt. A second rollover that arrives before software has cleared done sets an overrun error instead of done.

Software can also copy the reload value into the count at any moment, and it can advance a stopped count by one step. Either action, or both, is requested in the same write that sets the enable and run bits. Register access is a flat select, write-strobe and data port with a combinational read path. The count width is a parameter, so that a narrow instance can be used where a short rollover is wanted.

Top module: `itmr`

## Requirements
- R1: After reset the control word, the count and the next-interval register all read 0, and irq_o is low.
- R2: The control word (select 0) has run at bit 0 and interrupt enable at bit 6, and both read back as written. The copy-request bit (bit 4) and the step bit (bit 5) always read 0. Done is bit 7, error is bit 31, and every other bit reads 0.
- R3: The next-interval register (select 2) is a full 32-bit read/write register. A write to the count register (select 1) has no effect on the count.
- R4: While run is 1, the count rises by one in each cycle in which tick_i is high, and holds in any other cycle. A tick that arrives in the same cycle as a control-word write is dropped.
- R5: While run is 0, tick_i has no effect and the count keeps its value for read-back.
- R6: When the count advances from all ones, it loads the low CNT_W bits of the next-interval register, and done becomes 1.
- R7: A rollover while done is already 1 sets error (bit 31) and leaves done at 1.
- R8: Writing 1 to done or error clears that flag. Writing 0 to either leaves it unchanged.
- R9: A tick-driven rollover sets irq_o to the enable bit. After any control-word write, irq_o is low unless both done and enable are 1. A control write on its own never raises irq_o; only a step rollover can.
- R10: Writing the control word with bit 4 set copies the next-interval value into the count.
- R11: Writing the control word with bit 5 set and bit 0 clear advances the count by one, following the rollover rules of R6, R7 and R9. With bit 0 set, the step request is ignored.
- R12: Within one control write, the flag clears are applied first, then the copy, then the step. A copy together with a step therefore yields reload+1. A step rollover in the same write that clears done sets done and not error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle microsecond rate enable |
| sel_i | input | 2 | Register select: 0 control, 1 count, 2 next-interval |
| wr_i | input | 1 | Write strobe for the selected register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the selected register (combinational) |
| irq_o | output | 1 | Level interrupt request |

## Verification
The state that is hardest to reach is a rollover that lands on a chosen interval. At full width it would need billions of ticks, and the overrun error would need two such rollovers. The bench therefore builds an 8-bit instance and sweeps every reload value. For each value it copies the value in and runs exactly up to one tick short of the rollover, then one tick past it. The step and copy bits drive the count to all ones in a single write, which is how the same-write ordering cases of R12 and the done-to-error escalation are set up without any ticks.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned B_RUN   = 0;
  localparam int unsigned B_COPY  = 4;
  localparam int unsigned B_STEP  = 5;
  localparam int unsigned B_IE    = 6;
  localparam int unsigned B_DONE  = 7;
  localparam int unsigned B_ERR   = 31;

  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_COUNT  = 2'd1,
    SEL_RELOAD = 2'd2,
    SEL_NONE   = 2'd3
  } itmr_sel_e;
endpackage

// File: rtl/itmr_count.sv
module itmr_count #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             copy_i,
  input  logic             adv_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  // carry-out in the top bit, next value below it
  function automatic logic [CNT_W:0] bump(input logic [CNT_W-1:0] v);
    return {1'b0, v} + (CNT_W+1)'(1);
  endfunction

  logic [CNT_W-1:0] cnt_q, base, nxt;
  logic [CNT_W:0]   sum;

  always_comb begin
    base  = copy_i ? reload_i : cnt_q;
    sum   = bump(base);
    ovf_o = adv_i & sum[CNT_W];
    if (!adv_i)          nxt = base;
    else if (sum[CNT_W]) nxt = reload_i;
    else                 nxt = sum[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= nxt;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/itmr_csr.sv
module itmr_csr
  import itmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             ovf_i,
  output logic             run_o,
  output logic             ie_o,
  output logic             done_o,
  output logic             err_o,
  output logic             irq_o
);
  logic run_q, ie_q, done_q, err_q, irq_q;
  logic run_n, ie_n, done_n, err_n, irq_n, irq_set;

  always_comb begin
    run_n  = run_q;
    ie_n   = ie_q;
    done_n = done_q;
    err_n  = err_q;
    if (ctrl_wr_i) begin
      if (wdata_i[B_DONE]) done_n = 1'b0;
      if (wdata_i[B_ERR])  err_n  = 1'b0;
      ie_n  = wdata_i[B_IE];
      run_n = wdata_i[B_RUN];
    end
    if (ovf_i) begin
      if (done_n) err_n  = 1'b1;
      else        done_n = 1'b1;
    end
    irq_set = ovf_i & ie_n;
    if (ctrl_wr_i)  irq_n = (irq_q | irq_set) & done_n & ie_n;
    else if (ovf_i) irq_n = ie_n;
    else            irq_n = irq_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0; ie_q <= 1'b0; done_q <= 1'b0; err_q <= 1'b0; irq_q <= 1'b0;
    end else begin
      run_q <= run_n; ie_q <= ie_n; done_q <= done_n; err_q <= err_n; irq_q <= irq_n;
    end
  end

  assign run_o  = run_q;
  assign ie_o   = ie_q;
  assign done_o = done_q;
  assign err_o  = err_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/itmr.sv
module itmr
  import itmr_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_i,
  input  logic [1:0]  sel_i,
  input  logic        wr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        irq_o
);
  localparam int unsigned PAD_W = REG_W - CNT_W;

  logic             ctrl_wr, copy_evt, step_evt, tick_evt, adv_evt, ovf_evt;
  logic             run, ie, done, err;
  logic [REG_W-1:0] reload_q;
  logic [CNT_W-1:0] cnt, reload_lo;

  assign ctrl_wr   = wr_i && (sel_i == SEL_CTRL);
  assign copy_evt  = ctrl_wr && wdata_i[B_COPY];
  assign step_evt  = ctrl_wr && wdata_i[B_STEP] && !wdata_i[B_RUN];
  assign tick_evt  = tick_i && run && !ctrl_wr;
  assign adv_evt   = step_evt || tick_evt;
  assign reload_lo = reload_q[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n)                               reload_q <= '0;
    else if (wr_i && (sel_i == SEL_RELOAD))   reload_q <= wdata_i;
  end

  itmr_count #(.CNT_W(CNT_W)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .copy_i   (copy_evt),
    .adv_i    (adv_evt),
    .reload_i (reload_lo),
    .cnt_o    (cnt),
    .ovf_o    (ovf_evt)
  );

  itmr_csr u_csr (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_wr_i (ctrl_wr),
    .wdata_i   (wdata_i),
    .ovf_i     (ovf_evt),
    .run_o     (run),
    .ie_o      (ie),
    .done_o    (done),
    .err_o     (err),
    .irq_o     (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    case (sel_i)
      SEL_CTRL: begin
        rdata_o[B_RUN]  = run;
        rdata_o[B_IE]   = ie;
        rdata_o[B_DONE] = done;
        rdata_o[B_ERR]  = err;
      end
      SEL_COUNT:  rdata_o = {{PAD_W{1'b0}}, cnt} | '0;
      SEL_RELOAD: rdata_o = reload_q;
      default:    rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/itmr_chk.sv
module itmr_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctrl_wr,
  input logic             tick_evt,
  input logic             ovf_evt,
  input logic             run,
  input logic             ie,
  input logic             done,
  input logic             err,
  input logic             irq,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] reload_lo
);
  AST_IRQ_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (done && ie)); // R9
  AST_FROZEN_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ctrl_wr) |=> $stable(cnt)); // R5
  AST_TICK_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_evt && !ovf_evt) |=> (cnt == CNT_W'($past(cnt) + 1'b1))); // R4
  AST_OVF_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> (cnt == $past(reload_lo))); // R6
  AST_OVF_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> done); // R6
  AST_SECOND_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && done && !ctrl_wr) |=> (err && done)); // R7
endmodule

bind itmr itmr_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctrl_wr   (ctrl_wr),
  .tick_evt  (tick_evt),
  .ovf_evt   (ovf_evt),
  .run       (run),
  .ie        (ie),
  .done      (done),
  .err       (err),
  .irq       (irq_o),
  .cnt       (cnt),
  .reload_lo (reload_lo)
);

// File: tb/itmr_tb.sv
module itmr_tb;
  localparam int unsigned CW = 8;
  localparam int unsigned MOD = 1 << CW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [1:0]  sel = 2'd0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  itmr #(.CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .sel_i(sel), .wr_i(we),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk); sel = s; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] d);
    sel = s; #1; d = rdata;
  endtask

  task automatic ticks(input int n);
    repeat (n) begin @(negedge clk); tick = 1'b1; end
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic expect_state(input string tag, input logic [31:0] c_exp,
                              input logic [31:0] n_exp, input logic i_exp);
    logic [31:0] v;
    rd(2'd0, v); chk({tag, " ctrl"}, v, c_exp);
    rd(2'd1, v); chk({tag, " count"}, v, n_exp);
    chk({tag, " irq"}, {31'b0, irq}, {31'b0, i_exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    expect_state("R1", 32'h0, 32'h0, 1'b0);
    rd(2'd2, v); chk("R1 reload", v, 32'h0);
    // R2 layout: write-only bits read zero
    wr(2'd0, 32'hFFFF_FFFF);
    expect_state("R2", 32'h0000_0041, 32'h0, 1'b0);
    wr(2'd0, 32'h0);
    // R3 reload RW, count write ignored
    wr(2'd2, 32'hA5A5_1234);
    rd(2'd2, v); chk("R3 reload", v, 32'hA5A5_1234);
    wr(2'd1, 32'h77);
    rd(2'd1, v); chk("R3 count ignored", v, 32'h0);
    // R10 copy
    wr(2'd0, 32'h10);
    rd(2'd1, v); chk("R10 copy", v, 32'h34);
    // R11 step while stopped, ignored while running
    wr(2'd0, 32'h20);
    rd(2'd1, v); chk("R11 step", v, 32'h35);
    wr(2'd0, 32'h21);
    expect_state("R11 step with run", 32'h01, 32'h35, 1'b0);
    // R4 ticking
    ticks(5);
    rd(2'd1, v); chk("R4 five ticks", v, 32'h3A);
    repeat (4) @(negedge clk);
    rd(2'd1, v); chk("R4 no tick hold", v, 32'h3A);
    @(negedge clk); tick = 1'b1; sel = 2'd0; wdata = 32'h01; we = 1'b1;
    @(negedge clk); we = 1'b0; tick = 1'b0;
    rd(2'd1, v); chk("R4 tick during write dropped", v, 32'h3A);
    // R5 frozen when stopped
    wr(2'd0, 32'h0);
    ticks(10);
    rd(2'd1, v); chk("R5 frozen", v, 32'h3A);
    // R6 R7 R9 overflow by ticks
    wr(2'd2, 32'hFE);
    wr(2'd0, 32'h51);
    ticks(1);
    expect_state("R6 pre", 32'h41, 32'hFF, 1'b0);
    ticks(1);
    expect_state("R6 overflow", 32'hC1, 32'hFE, 1'b1);
    ticks(2);
    expect_state("R7 second overflow", 32'h8000_00C1, 32'hFE, 1'b1);
    // R8 W1C and R9 drop rules
    wr(2'd0, 32'h8000_0040);
    expect_state("R8 clear err", 32'hC0, 32'hFE, 1'b1);
    wr(2'd0, 32'h0);
    expect_state("R9 ie off drops irq", 32'h80, 32'hFE, 1'b0);
    wr(2'd0, 32'h40);
    expect_state("R9 write never raises", 32'hC0, 32'hFE, 1'b0);
    wr(2'd0, 32'h80);
    expect_state("R8 clear done", 32'h00, 32'hFE, 1'b0);
    // R12 ordering
    wr(2'd2, 32'hFF);
    wr(2'd0, 32'h30);
    expect_state("R12 copy then step overflow", 32'h80, 32'hFF, 1'b0);
    wr(2'd0, 32'h30);
    expect_state("R7 step overflow with done", 32'h8000_0080, 32'hFF, 1'b0);
    wr(2'd0, 32'h8000_00B0);
    expect_state("R12 clear before step", 32'h80, 32'hFF, 1'b0);
    wr(2'd0, 32'h8000_00E0);
    expect_state("R11 step overflow irq", 32'hC0, 32'hFF, 1'b1);
    wr(2'd0, 32'h8000_0080);
    expect_state("R9 clear done drops irq", 32'h00, 32'hFF, 1'b0);
    wr(2'd2, 32'h40);
    wr(2'd0, 32'h30);
    rd(2'd1, v); chk("R12 copy plus step", v, 32'h41);
    wr(2'd0, 32'h80);
    // R6 sweep of every reload value
    for (int r = 0; r < MOD; r++) begin
      int n;
      n = MOD - r;
      wr(2'd2, 32'(r));
      wr(2'd0, 32'h8000_0091);
      ticks(n - 1);
      rd(2'd0, v); chk("R6 sweep pre ctrl", v, 32'h01);
      rd(2'd1, v); chk("R4 sweep pre count", v, 32'(MOD - 1));
      ticks(1);
      rd(2'd0, v); chk("R6 sweep done", v, 32'h81);
      rd(2'd1, v); chk("R6 sweep reload", v, 32'(r));
      wr(2'd0, 32'h0);
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule